// File: doc/BRIEF.md
# Processor reset vector sequencer

This block is the reset front end of a small 8-bit processor core with a 16-bit address bus. It watches the core's active-low reset request. It qualifies that request by a minimum low time. When the request is released, it steps through a fixed start-up sequence. During the sequence it drives the address bus, a read strobe and an active-low vector-pull output. Near the end of the sequence it reads the two-byte start address from the top of memory and loads it into the program counter.

At the start of the sequence, the block forces the hardware-owned bits of the status register. When the vector has been assembled, it raises a one-cycle done pulse on the first opcode fetch. From then on it keeps the run indication high, so the rest of the core can take over fetching.

A ready input stalls the sequence cycle by cycle. That input has no influence at all while the reset request is held low. Instruction decode and execution, the interrupt sequences and the memory itself live elsewhere.

Top module: `cpu_reset_sequencer`

## Requirements
- R1: A reset request counts only after `res_n_i` has been sampled low on at least MIN_LOW (default 2) consecutive rising clock edges. If the request is released earlier, no sequence starts: `rd_o` stays 0, `vp_n_o` stays 1 and `run_o` stays 0 until a valid request arrives.
- R2: While `res_n_i` is low, `rdy_i` has no effect. The sequence that follows a valid request is the same whatever `rdy_i` did during the low time.
- R3: With `rdy_i` high, the sequence occupies exactly SEQ_LEN (default 7) cycles after the first rising edge that samples `res_n_i` high. Cycles 1 to 5 are read-only dummy cycles with `rd_o`=1 and `vp_n_o`=1. `done_o` is first high in cycle 8.
- R4: Cycle 6 reads address 0xFFFC (the low byte) and cycle 7 reads 0xFFFD (the high byte). After the sequence, `pc_o` equals {byte read at 0xFFFD, byte read at 0xFFFC}.
- R5: The status byte uses the layout bit7 N, bit6 V, bit5 one, bit4 B, bit3 D (decimal), bit2 I (interrupt disable), bit1 Z, bit0 C. On entry to the sequence, `status_o` becomes `(status_i & 0xC3) | 0x34`. So bits 5, 4 and 2 are 1, bit 3 is 0, and bits 7, 6, 1 and 0 come from `status_i`. It holds that value until the done cycle has passed.
- R6: `vp_n_o` is 0 only in the two vector read cycles, with `rd_o`=1 and the address at 0xFFFC or 0xFFFD. It is 1 at every other time.
- R7: `rdy_i` sampled low at a rising edge during the sequence holds the current cycle: the address, strobes and cycle position stay unchanged and no vector byte is taken. Each stalled edge lengthens the sequence by one cycle.
- R8: `res_n_i` sampled low at any point, including partway through the sequence, makes the outputs idle from the next cycle on (`rd_o`=0, `vp_n_o`=1, `run_o`=0). The sequence resumes only after a fresh valid request.
- R9: After the asynchronous block reset `arst_n`, the outputs are idle: `rd_o`=0, `vp_n_o`=1, `done_o`=0, `run_o`=0, `status_o`=0x34. They stay idle until the first valid request has been released.
- R10: In the done cycle, `addr_o` equals the loaded `pc_o` with `rd_o`=1. `done_o` lasts one cycle when `rdy_i` is high, and `run_o` stays 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| res_n_i | input | 1 | Active-low processor reset request being watched |
| rdy_i | input | 1 | Ready; low stalls the sequence |
| rd_data_i | input | 8 | Read data from memory |
| status_i | input | 8 | Core's current status byte (software-owned bits) |
| addr_o | output | 16 | Address bus |
| rd_o | output | 1 | Read strobe |
| vp_n_o | output | 1 | Active-low vector pull |
| pc_o | output | 16 | Program counter loaded from the vector |
| status_o | output | 8 | Status byte with hardware bits applied |
| done_o | output | 1 | High on the first opcode fetch after the sequence |
| run_o | output | 1 | Normal fetching enabled |

## Verification
The bench builds the block with its default parameters: MIN_LOW of 2, a seven-cycle sequence, and a 16-bit address with the vector at 0xFFFC. Memory is a 256-byte array indexed by the low address byte.

It sweeps the low time from one to four cycles, so it covers both sides of the qualification threshold. For each low time, it places a two-cycle ready stall at every sequence position in turn, and it toggles ready throughout the low time. For each case it computes the cycle positions, the vector value and the merged status arithmetically. A separate case pulls reset low during a vector read cycle and then gives a pulse that is too short, to show the abort and the need for a fresh request.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_SEQ,
    ST_FETCH,
    ST_RUN
  } seq_st_e;

  // Hardware-owned status bits: bit5 one, bit4 B, bit3 D, bit2 I
  localparam logic [7:0] HW_MASK = 8'h3C;
  localparam logic [7:0] HW_VAL  = 8'h34;

  function automatic logic [7:0] status_merge(input logic [7:0] sw);
    return (sw & ~HW_MASK) | HW_VAL;
  endfunction

endpackage

// File: rtl/rvs_res_qual.sv
module rvs_res_qual #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic res_n_i,
  output logic low_ok_o
);

  localparam int CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;

  always_comb begin
    cnt_en  = 1'b1;
    cnt_nxt = '0;
    if (!res_n_i) begin
      if (cnt_q == CNT_MAX) begin
        cnt_en  = 1'b0;
        cnt_nxt = cnt_q;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign low_ok_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/rvs_seq_fsm.sv
module rvs_seq_fsm
  import rvs_pkg::*;
#(
  parameter int SEQ_LEN = 7
) (
  input  logic    clk,
  input  logic    arst_n,
  input  logic    res_n_i,
  input  logic    rdy_i,
  input  logic    low_ok_i,
  output seq_st_e st_o,
  output logic    start_o,
  output logic    vec_lo_o,
  output logic    vec_hi_o
);

  localparam int CYW = $clog2(SEQ_LEN + 1);
  localparam logic [CYW-1:0] LAST_CYC = CYW'(SEQ_LEN);
  localparam logic [CYW-1:0] LO_CYC   = CYW'(SEQ_LEN - 1);

  seq_st_e        st_q, st_nxt;
  logic [CYW-1:0] cyc_q, cyc_nxt;

  always_comb begin
    st_nxt  = st_q;
    cyc_nxt = cyc_q;
    start_o = 1'b0;
    if (!res_n_i) begin
      st_nxt  = ST_HOLD;
      cyc_nxt = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: ;
        ST_HOLD: begin
          if (low_ok_i) begin
            st_nxt  = ST_SEQ;
            cyc_nxt = CYW'(1);
            start_o = 1'b1;
          end else begin
            st_nxt = ST_IDLE;
          end
        end
        ST_SEQ: begin
          if (rdy_i) begin
            if (cyc_q == LAST_CYC) begin
              st_nxt  = ST_FETCH;
              cyc_nxt = '0;
            end else begin
              cyc_nxt = cyc_q + 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (rdy_i) st_nxt = ST_RUN;
        end
        ST_RUN: ;
        default: st_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q  <= ST_IDLE;
      cyc_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cyc_q <= cyc_nxt;
    end
  end

  assign st_o     = st_q;
  assign vec_lo_o = (st_q == ST_SEQ) && (cyc_q == LO_CYC);
  assign vec_hi_o = (st_q == ST_SEQ) && (cyc_q == LAST_CYC);

endmodule

// File: rtl/rvs_vec_load.sv
module rvs_vec_load
  import rvs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  input  logic              ld_status_i,
  input  logic              track_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [7:0]        status_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [7:0]        status_o
);

  logic [DATA_W-1:0] lo_q;
  logic [ADDR_W-1:0] pc_q, pc_nxt;
  logic [7:0]        st_q, st_nxt;
  logic              st_en;

  always_comb begin
    pc_nxt = {rd_data_i, lo_q};
    st_en  = ld_status_i || track_i;
    st_nxt = ld_status_i ? status_merge(status_i) : status_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lo_q <= '0;
    end else if (cap_lo_i) begin
      lo_q <= rd_data_i;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pc_q <= '0;
    end else if (cap_hi_i) begin
      pc_q <= pc_nxt;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q <= HW_VAL;
    end else if (st_en) begin
      st_q <= st_nxt;
    end
  end

  assign pc_o     = pc_q;
  assign status_o = st_q;

endmodule

// File: rtl/cpu_reset_sequencer.sv
module cpu_reset_sequencer
  import rvs_pkg::*;
#(
  parameter int               ADDR_W   = 16,
  parameter int               DATA_W   = 8,
  parameter int               SEQ_LEN  = 7,
  parameter int               MIN_LOW  = 2,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              res_n_i,
  input  logic              rdy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [7:0]        status_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o,
  output logic              vp_n_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [7:0]        status_o,
  output logic              done_o,
  output logic              run_o
);

  localparam logic [ADDR_W-1:0] VEC_HI = VEC_BASE + 1'b1;

  seq_st_e st;
  logic    low_ok, start, vec_lo, vec_hi;

  rvs_res_qual #(.MIN_LOW(MIN_LOW)) u_qual (
    .clk      (clk),
    .arst_n   (arst_n),
    .res_n_i  (res_n_i),
    .low_ok_o (low_ok)
  );

  rvs_seq_fsm #(.SEQ_LEN(SEQ_LEN)) u_fsm (
    .clk      (clk),
    .arst_n   (arst_n),
    .res_n_i  (res_n_i),
    .rdy_i    (rdy_i),
    .low_ok_i (low_ok),
    .st_o     (st),
    .start_o  (start),
    .vec_lo_o (vec_lo),
    .vec_hi_o (vec_hi)
  );

  rvs_vec_load #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_load (
    .clk         (clk),
    .arst_n      (arst_n),
    .cap_lo_i    (vec_lo && rdy_i),
    .cap_hi_i    (vec_hi && rdy_i),
    .ld_status_i (start),
    .track_i     (st == ST_RUN),
    .rd_data_i   (rd_data_i),
    .status_i    (status_i),
    .pc_o        (pc_o),
    .status_o    (status_o)
  );

  always_comb begin
    if (vec_lo)      addr_o = VEC_BASE;
    else if (vec_hi) addr_o = VEC_HI;
    else             addr_o = pc_o;
  end

  assign rd_o   = (st == ST_SEQ) || (st == ST_FETCH) || (st == ST_RUN);
  assign vp_n_o = !(vec_lo || vec_hi);
  assign done_o = (st == ST_FETCH);
  assign run_o  = (st == ST_FETCH) || (st == ST_RUN);

endmodule

// File: rtl/rvs_checker.sv
module rvs_checker #(
  parameter int               ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_BASE = 16'hFFFC
) (
  input logic              clk,
  input logic              arst_n,
  input logic              res_n_i,
  input logic              rdy_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              rd_o,
  input logic              vp_n_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [7:0]        status_o,
  input logic              done_o,
  input logic              run_o
);

  localparam logic [ADDR_W-1:0] VEC_HI = VEC_BASE + 1'b1;

  AST_VP_ON_VECTOR: assert property (@(posedge clk) disable iff (!arst_n)
    !vp_n_o |-> (rd_o && (addr_o == VEC_BASE || addr_o == VEC_HI))); // R6

  AST_LOW_ABORTS: assert property (@(posedge clk) disable iff (!arst_n)
    !res_n_i |=> (vp_n_o && !rd_o && !run_o)); // R8

  AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!arst_n)
    (!vp_n_o && addr_o == VEC_HI) |-> $past(!vp_n_o)); // R4

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (!vp_n_o && !rdy_i && res_n_i) |=> ($stable(addr_o) && !vp_n_o)); // R7

  AST_DONE_AT_PC: assert property (@(posedge clk) disable iff (!arst_n)
    done_o |-> (rd_o && vp_n_o && run_o && addr_o == pc_o)); // R10

  AST_DONE_STATUS: assert property (@(posedge clk) disable iff (!arst_n)
    done_o |-> (status_o[5:2] == 4'b1101)); // R5

  AST_DONE_AFTER_VEC: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(done_o) |-> ($past(!vp_n_o) && $past(addr_o) == VEC_HI)); // R3

endmodule

bind cpu_reset_sequencer rvs_checker #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .res_n_i  (res_n_i),
  .rdy_i    (rdy_i),
  .addr_o   (addr_o),
  .rd_o     (rd_o),
  .vp_n_o   (vp_n_o),
  .pc_o     (pc_o),
  .status_o (status_o),
  .done_o   (done_o),
  .run_o    (run_o)
);

// File: tb/cpu_reset_sequencer_bench.sv
module cpu_reset_sequencer_bench;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        res_n_i = 1'b1;
  logic        rdy_i = 1'b1;
  logic [7:0]  rd_data_i;
  logic [7:0]  status_i = 8'h00;
  logic [15:0] addr_o, pc_o;
  logic        rd_o, vp_n_o, done_o, run_o;
  logic [7:0]  status_o;

  logic [7:0] mem [256];
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rd_data_i = mem[addr_o[7:0]];

  cpu_reset_sequencer u_cpu_reset_sequencer (
    .clk(clk), .arst_n(arst_n), .res_n_i(res_n_i), .rdy_i(rdy_i),
    .rd_data_i(rd_data_i), .status_i(status_i), .addr_o(addr_o),
    .rd_o(rd_o), .vp_n_o(vp_n_o), .pc_o(pc_o), .status_o(status_o),
    .done_o(done_o), .run_o(run_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk(!rd_o && vp_n_o && !run_o && !done_o, req,
          {rd_o, vp_n_o, run_o, done_o}, 4'b0100);
    end
  endtask

  // Valid or short request of low_len cycles, then the sequence with a
  // two-edge ready stall at position stall_pos (0 = none).
  task automatic run_case(input int low_len, input int stall_pos,
                          input logic [15:0] vec, input logic [7:0] si);
    int pos;
    int stalls;
    logic [7:0] merged;
    mem[8'hFC] = vec[7:0];
    mem[8'hFD] = vec[15:8];
    status_i = si;
    merged = (si & 8'hC3) | 8'h34;
    @(negedge clk);
    res_n_i = 1'b0;
    for (int i = 0; i < low_len; i++) begin
      rdy_i = i[0];  // R2: ready toggles while request is low
      @(negedge clk);
    end
    chk(!rd_o && vp_n_o && !run_o, "R8 idle while low", {rd_o, vp_n_o, run_o}, 3'b010);
    res_n_i = 1'b1;
    rdy_i = 1'b1;
    if (low_len < 2) begin
      check_idle("R1 short pulse", 10);
      return;
    end
    pos = 1;
    stalls = 2;
    while (pos <= 9) begin
      @(negedge clk);
      if (pos <= 5) begin
        chk(rd_o && vp_n_o && !done_o, "R3 dummy cycle", {rd_o, vp_n_o, done_o}, 3'b110);
        if (pos == 1)
          chk(status_o == merged, "R5 status at start", status_o, merged);
      end else if (pos == 6) begin
        chk(!vp_n_o && rd_o && addr_o == 16'hFFFC, "R4 R6 low vector",
            {vp_n_o, addr_o}, {1'b0, 16'hFFFC});
      end else if (pos == 7) begin
        chk(!vp_n_o && rd_o && addr_o == 16'hFFFD, "R4 R6 high vector",
            {vp_n_o, addr_o}, {1'b0, 16'hFFFD});
      end else if (pos == 8) begin
        chk(done_o && run_o && vp_n_o, "R3 done on cycle 8", {done_o, run_o, vp_n_o}, 3'b111);
        chk(pc_o == vec && addr_o == vec && rd_o, "R4 R10 pc loaded", {pc_o, addr_o}, {vec, vec});
        chk(status_o == merged, "R5 status merged", status_o, merged);
      end else begin
        chk(!done_o && run_o && vp_n_o, "R10 done one cycle", {done_o, run_o, vp_n_o}, 3'b011);
      end
      if (pos == stall_pos && stalls > 0) begin
        rdy_i = 1'b0;  // R7 stall holds this position
        stalls--;
      end else begin
        rdy_i = 1'b1;
        pos++;
      end
    end
    rdy_i = 1'b1;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 8'(a * 7 + 3);
    repeat (3) @(negedge clk);
    chk(!rd_o && vp_n_o && !done_o && !run_o && status_o == 8'h34, "R9 reset state",
        {rd_o, vp_n_o, done_o, run_o, status_o}, {4'b0100, 8'h34});
    arst_n = 1'b1;
    check_idle("R9 idle after power-up", 5);

    for (int low = 1; low <= 4; low++) begin
      for (int sp = 0; sp <= 7; sp++) begin
        run_case(low, sp, 16'h1234 ^ 16'(low << 12) ^ 16'(sp * 16'h0111),
                 8'(low * 37 + sp * 11));
      end
    end

    // R8: abort on the low vector cycle, then a short pulse must not restart
    mem[8'hFC] = 8'h00;
    mem[8'hFD] = 8'h80;
    @(negedge clk);
    res_n_i = 1'b0;
    repeat (3) @(negedge clk);
    res_n_i = 1'b1;
    repeat (6) @(negedge clk);
    chk(!vp_n_o && addr_o == 16'hFFFC, "R8 reached vector", addr_o, 16'hFFFC);
    res_n_i = 1'b0;
    @(negedge clk);
    chk(vp_n_o && !rd_o && !run_o, "R8 abort idle", {vp_n_o, rd_o, run_o}, 3'b100);
    res_n_i = 1'b1;
    check_idle("R8 R1 needs fresh request", 12);
    run_case(2, 0, 16'hBEEF, 8'hFF);
    run_case(3, 6, 16'h0001, 8'h00);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule